// File: doc/BRIEF.md
# Table-Driven Analog Limit Checker

The block is a scanning processor that runs beside host software and shares host memory with it only through a memory request port. A scan begins by reading one fixed memory cell, which holds the base address of a work table. Each table entry is three consecutive words: a channel word, a low limit and a high limit. For each entry the block fetches the three words, puts the channel number on the converter's channel select and pulses the converter start. When the converter reports done, it compares the returned sample with that entry's limits. An out-of-limit sample raises a one-cycle alarm strobe that carries the entry's position in the table and the sample value.

A channel word with its top bit set ends the table. The block then either reloads the pointer cell and scans again, or parks idle while the stop input is high. Host software can therefore rewrite the limits or repoint the table between scans without stopping the block.

The memory request side is valid/ready. The block raises `mem_req_valid` with an address and holds both, unchanged, until a cycle in which `mem_req_ready` is high. At most one request is outstanding at a time. Read data returns on `mem_rsp_valid` with no back-pressure: the block accepts the response in any cycle after its request was taken. The converter and alarm pins are plain strobes.

Top module: `limit_scanner`

## Requirements
- R1: After reset `mem_req_valid`, `adc_start` and `alarm_valid` are low, and no memory request is made while `scan_stop` stays high.
- R2: Every scan begins with a memory read of the pointer cell at address PTR_ADDR (default 0).
- R3: Entry k occupies words base+3k (channel), base+3k+1 (low limit) and base+3k+2 (high limit), where base is the value read from the pointer cell. `adc_chan` carries bits CHW-1:0 of the channel word and stays unchanged from the start pulse until done.
- R4: A channel word with bit DW-1 set ends the scan. No limit words are read and no converter start is issued for it.
- R5: Each entry produces exactly one `adc_start` pulse, one cycle wide, issued after its high limit has been read and while no memory request is pending.
- R6: Samples and limits compare as unsigned numbers. A sample strictly below the low limit, or strictly above the high limit, is out of limit. A sample equal to either limit is in range.
- R7: For an out-of-limit sample, `alarm_valid` is high for exactly the one cycle after `adc_done`. In that cycle `alarm_index` holds the entry's 0-based table position and `alarm_sample` holds the sample. No alarm is raised for an in-range sample.
- R8: At the end marker, the block goes idle if `scan_stop` is high and otherwise starts a new scan with a fresh pointer read. An idle block restarts when `scan_stop` goes low.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with a stable `mem_req_addr` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_stop | input | 1 | Park idle at the end of the current scan |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DW | Read data |
| adc_chan | output | CHW | Converter channel select |
| adc_start | output | 1 | Converter start pulse |
| adc_done | input | 1 | Converter conversion complete |
| adc_data | input | DW | Converter sample |
| alarm_valid | output | 1 | Out-of-limit strobe |
| alarm_index | output | IXW | Table position of the offending entry |
| alarm_sample | output | DW | Offending sample |

## Verification
The checker assumes that `mem_rsp_valid` comes only for a request that was accepted, once per request. It also assumes that `adc_done` pulses once for each start and never arrives without one. The bench memory model meets this by answering one accepted request a fixed three cycles later. Its converter model raises done exactly once, three cycles after each start pulse. The ready line follows a repeating pattern that is low one cycle in three, so requests see back-pressure but always drain.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_CONV
  } lsc_state_e;

  typedef enum logic [1:0] {
    WD_PTR,
    WD_CHAN,
    WD_LO,
    WD_HI
  } lsc_word_e;
endpackage

// File: rtl/lsc_limit_cmp.sv
module lsc_limit_cmp #(
  parameter int DW         = 16,
  parameter bit SIGNED_CMP = 1'b0
) (
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] lim_lo,
  input  logic [DW-1:0] lim_hi,
  output logic          below,
  output logic          above,
  output logic          out_of_range
);
  generate
    if (SIGNED_CMP) begin : g_signed
      assign below = $signed(sample) < $signed(lim_lo);
      assign above = $signed(sample) > $signed(lim_hi);
    end else begin : g_unsigned
      assign below = sample < lim_lo;
      assign above = sample > lim_hi;
    end
  endgenerate

  assign out_of_range = below | above;
endmodule

// File: rtl/lsc_seq.sv
module lsc_seq
  import lsc_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 16,
  parameter int          CHW      = 4,
  parameter int          IXW      = 8,
  parameter logic [AW-1:0] PTR_ADDR = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scan_stop,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [AW-1:0]  mem_req_addr,
  input  logic           mem_rsp_valid,
  input  logic [DW-1:0]  mem_rsp_data,
  output logic [CHW-1:0] adc_chan,
  output logic           adc_start,
  input  logic           adc_done,
  input  logic           cmp_out,
  input  logic [DW-1:0]  adc_data,
  output logic [DW-1:0]  lim_lo,
  output logic [DW-1:0]  lim_hi,
  output logic           alarm_valid,
  output logic [IXW-1:0] alarm_index,
  output logic [DW-1:0]  alarm_sample
);
  localparam int ENDB = DW - 1;

  lsc_state_e     state_q;
  lsc_word_e      word_q;
  logic           started_q;
  logic [AW-1:0]  addr_q;
  logic [IXW-1:0] idx_q;

  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = (word_q == WD_PTR) ? PTR_ADDR : addr_q;
  assign adc_start     = (state_q == ST_CONV) && !started_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      word_q       <= WD_PTR;
      started_q    <= 1'b0;
      addr_q       <= '0;
      idx_q        <= '0;
      adc_chan     <= '0;
      lim_lo       <= '0;
      lim_hi       <= '0;
      alarm_valid  <= 1'b0;
      alarm_index  <= '0;
      alarm_sample <= '0;
    end else begin
      alarm_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (!scan_stop) begin
            state_q <= ST_REQ;
            word_q  <= WD_PTR;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            unique case (word_q)
              WD_PTR: begin
                addr_q  <= AW'(mem_rsp_data);
                idx_q   <= '0;
                word_q  <= WD_CHAN;
                state_q <= ST_REQ;
              end
              WD_CHAN: begin
                if (mem_rsp_data[ENDB]) begin
                  word_q  <= WD_PTR;
                  state_q <= scan_stop ? ST_IDLE : ST_REQ;
                end else begin
                  adc_chan <= mem_rsp_data[CHW-1:0];
                  addr_q   <= addr_q + 1'b1;
                  word_q   <= WD_LO;
                  state_q  <= ST_REQ;
                end
              end
              WD_LO: begin
                lim_lo  <= mem_rsp_data;
                addr_q  <= addr_q + 1'b1;
                word_q  <= WD_HI;
                state_q <= ST_REQ;
              end
              WD_HI: begin
                lim_hi    <= mem_rsp_data;
                addr_q    <= addr_q + 1'b1;
                started_q <= 1'b0;
                state_q   <= ST_CONV;
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
        ST_CONV: begin
          started_q <= 1'b1;
          if (adc_done && started_q) begin
            alarm_valid  <= cmp_out;
            alarm_index  <= idx_q;
            alarm_sample <= adc_data;
            idx_q        <= idx_q + 1'b1;
            word_q       <= WD_CHAN;
            state_q      <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/limit_scanner.sv
module limit_scanner #(
  parameter int            AW         = 16,
  parameter int            DW         = 16,
  parameter int            CHW        = 4,
  parameter int            IXW        = 8,
  parameter logic [AW-1:0] PTR_ADDR   = '0,
  parameter bit            SIGNED_CMP = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scan_stop,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [AW-1:0]  mem_req_addr,
  input  logic           mem_rsp_valid,
  input  logic [DW-1:0]  mem_rsp_data,
  output logic [CHW-1:0] adc_chan,
  output logic           adc_start,
  input  logic           adc_done,
  input  logic [DW-1:0]  adc_data,
  output logic           alarm_valid,
  output logic [IXW-1:0] alarm_index,
  output logic [DW-1:0]  alarm_sample
);
  logic [DW-1:0] lim_lo, lim_hi;
  logic          below, above, cmp_out;

  lsc_limit_cmp #(.DW(DW), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
    .sample       (adc_data),
    .lim_lo       (lim_lo),
    .lim_hi       (lim_hi),
    .below        (below),
    .above        (above),
    .out_of_range (cmp_out)
  );

  lsc_seq #(
    .AW(AW), .DW(DW), .CHW(CHW), .IXW(IXW), .PTR_ADDR(PTR_ADDR)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .scan_stop     (scan_stop),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .adc_chan      (adc_chan),
    .adc_start     (adc_start),
    .adc_done      (adc_done),
    .cmp_out       (cmp_out),
    .adc_data      (adc_data),
    .lim_lo        (lim_lo),
    .lim_hi        (lim_hi),
    .alarm_valid   (alarm_valid),
    .alarm_index   (alarm_index),
    .alarm_sample  (alarm_sample)
  );

  logic unused_flags;
  assign unused_flags = below ^ above;
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int AW  = 16,
  parameter int CHW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic [AW-1:0]  mem_req_addr,
  input logic [CHW-1:0] adc_chan,
  input logic           adc_start,
  input logic           adc_done,
  input logic           alarm_valid
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R5

  AST_START_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> !mem_req_valid); // R5

  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> $stable(adc_chan)); // R3

  AST_ALARM_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_valid |-> $past(adc_done)); // R7

  AST_ALARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_valid |=> !alarm_valid); // R7
endmodule

bind limit_scanner lsc_checker #(.AW(AW), .CHW(CHW)) u_lsc_checker (.*);

// File: tb/test_limit_scanner.sv
module test_limit_scanner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_stop = 1'b1;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic [3:0]  adc_chan;
  logic        adc_start, adc_done = 1'b0;
  logic [15:0] adc_data = '0;
  logic        alarm_valid;
  logic [7:0]  alarm_index;
  logic [15:0] alarm_sample;

  always #5 clk = ~clk;

  limit_scanner i_limit_scanner (.*);

  // vector: {flag, channel, low, high, sample}
  localparam logic [67:0] VEC [8] = '{
    {4'd0, 16'd1, 16'd100, 16'd200, 16'd150},
    {4'd1, 16'd2, 16'd100, 16'd200, 16'd99},
    {4'd0, 16'd3, 16'd100, 16'd200, 16'd100},
    {4'd0, 16'd4, 16'd100, 16'd200, 16'd200},
    {4'd1, 16'd5, 16'd100, 16'd200, 16'd201},
    {4'd0, 16'd6, 16'd0,   16'hFFFF, 16'd0},
    {4'd0, 16'd7, 16'd500, 16'd500, 16'd500},
    {4'd1, 16'd8, 16'd10,  16'd20,  16'hFFFF}
  };

  logic [15:0] mem [64];
  logic [15:0] adc_val [16];

  // memory model: three-cycle response, ready low one cycle in three
  int unsigned rdy_cnt = 0;
  logic        pend = 1'b0;
  logic [1:0]  dly = '0;
  logic [15:0] pdata = '0;
  int n_ptr = 0, n_req = 0, n_start = 0, n_alarm = 0, n_bad = 0;
  logic [3:0]  rec_chan [64];
  logic [7:0]  rec_aidx [64];
  logic [15:0] rec_asmp [64];
  logic [1:0]  adc_cnt = '0;
  logic [3:0]  adc_ch_lat = '0;
  logic        prev_alarm = 1'b0;

  always @(posedge clk) begin
    rdy_cnt       <= rdy_cnt + 1;
    mem_req_ready <= (rdy_cnt % 3) != 0;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      pend  <= 1'b1;
      dly   <= 2'd2;
      pdata <= mem[mem_req_addr[5:0]];
      n_req <= n_req + 1;
      if (mem_req_addr == 16'd0) n_ptr <= n_ptr + 1;
    end else if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= pdata;
        pend          <= 1'b0;
      end else dly <= dly - 1'b1;
    end
    adc_done <= 1'b0;
    if (adc_start) begin
      adc_cnt    <= 2'd3;
      adc_ch_lat <= adc_chan;
      if (n_start < 64) rec_chan[n_start] <= adc_chan;
      n_start <= n_start + 1;
    end else if (adc_cnt != 0) begin
      adc_cnt <= adc_cnt - 1'b1;
      if (adc_cnt == 2'd1) begin
        adc_done <= 1'b1;
        adc_data <= adc_val[adc_ch_lat];
      end
    end
    prev_alarm <= alarm_valid;
    if (rst_n && alarm_valid) begin
      if (n_alarm < 64) begin
        rec_aidx[n_alarm] <= alarm_index;
        rec_asmp[n_alarm] <= alarm_sample;
      end
      n_alarm <= n_alarm + 1;
      if (prev_alarm) n_bad <= n_bad + 1;
    end
  end

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2ms;
    if (!finished) begin
      fails++;
      tests++;
      $display("[TB] FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int b_ptr, b_req, b_start, b_alarm, exp_alarm;
    for (int i = 0; i < 64; i++) mem[i] = 16'h8000;
    for (int i = 0; i < 16; i++) adc_val[i] = '0;
    mem[0] = 16'd16;
    for (int i = 0; i < 8; i++) begin
      mem[16 + 3*i]     = VEC[i][63:48];
      mem[16 + 3*i + 1] = VEC[i][47:32];
      mem[16 + 3*i + 2] = VEC[i][31:16];
      adc_val[VEC[i][51:48]] = VEC[i][15:0];
    end
    mem[40] = 16'h8000;

    wait_cyc(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req_valid == 1'b0, "R1 req idle", int'(mem_req_valid), 0);
    chk(adc_start == 1'b0, "R1 start idle", int'(adc_start), 0);
    chk(alarm_valid == 1'b0, "R1 alarm idle", int'(alarm_valid), 0);
    wait_cyc(20);
    chk(n_req == 0, "R1 no request while stopped", n_req, 0);

    // one scan of the vector table
    b_ptr = n_ptr; b_req = n_req; b_start = n_start; b_alarm = n_alarm;
    scan_stop = 1'b0;
    while (!mem_req_valid) @(negedge clk);
    chk(mem_req_addr == 16'd0, "R2 pointer cell first", int'(mem_req_addr), 0);
    scan_stop = 1'b1;
    wait_cyc(600);
    chk(n_ptr - b_ptr == 1, "R8 stop parks after one scan", n_ptr - b_ptr, 1);
    chk(n_req - b_req == 26, "R4 marker read ends table", n_req - b_req, 26);
    chk(n_start - b_start == 8, "R5 one start per entry", n_start - b_start, 8);
    chk(mem_req_valid == 1'b0, "R8 idle after stop", int'(mem_req_valid), 0);
    exp_alarm = 0;
    for (int i = 0; i < 8; i++) begin
      chk(rec_chan[b_start + i] == VEC[i][51:48], "R3 channel select",
          int'(rec_chan[b_start + i]), int'(VEC[i][51:48]));
      if (VEC[i][64]) begin
        chk(rec_aidx[b_alarm + exp_alarm] == 8'(i), "R7 alarm index",
            int'(rec_aidx[b_alarm + exp_alarm]), i);
        chk(rec_asmp[b_alarm + exp_alarm] == VEC[i][15:0], "R6 alarm sample",
            int'(rec_asmp[b_alarm + exp_alarm]), int'(VEC[i][15:0]));
        exp_alarm++;
      end
    end
    chk(n_alarm - b_alarm == exp_alarm, "R6 alarm count, equal limits in range",
        n_alarm - b_alarm, exp_alarm);
    chk(n_bad == 0, "R7 strobe one cycle", n_bad, 0);

    // free running: pointer reloaded every scan
    b_ptr = n_ptr;
    scan_stop = 1'b0;
    wait_cyc(1500);
    scan_stop = 1'b1;
    wait_cyc(600);
    chk(n_ptr - b_ptr >= 3, "R8 pointer reloaded", n_ptr - b_ptr, 3);
    chk(mem_req_valid == 1'b0, "R8 idle after late stop", int'(mem_req_valid), 0);
    chk(n_bad == 0, "R7 strobe one cycle over many scans", n_bad, 0);

    // empty table: marker with low bits set at the first entry
    mem[0] = 16'd48;
    mem[48] = 16'h8003;
    b_ptr = n_ptr; b_req = n_req; b_start = n_start; b_alarm = n_alarm;
    scan_stop = 1'b0;
    while (n_ptr == b_ptr) @(negedge clk);
    scan_stop = 1'b1;
    wait_cyc(100);
    chk(n_start - b_start == 0, "R4 empty table no start", n_start - b_start, 0);
    chk(n_req - b_req == 2, "R4 empty table two reads", n_req - b_req, 2);
    chk(n_alarm - b_alarm == 0, "R7 empty table no alarm", n_alarm - b_alarm, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule